// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a legacy peripheral-combo device on a byte-wide I/O bus. Software reaches it through two byte locations. One is an index port that picks a setup register. The other is a data port that reads or writes the register the index points at. Three 8-bit setup registers sit behind the pair: function enable, function address and power/test. After reset, reads of the index port first return a two-byte identification sequence and then the stored index.

A 5-bit strap input is sampled while reset is held. It selects one of 32 default sets for the three registers; strap 1 is the usual board setting. The block decodes the registers continuously into enable, I/O base and IRQ number outputs for one parallel port, two serial ports, a floppy controller and a disk controller. Each accepted register write raises a one-cycle strobe, so downstream logic knows when to re-read the map.

Bus accesses are single-cycle strobes. `rd_en` and `wr_en` are never both high in the same cycle. Accesses need no back-pressure, because every access completes in the cycle it is presented. Read data is combinational during the read strobe and is 0x00 at all other times.

Top module: `sio_cfg_port`

## Requirements
- R1: While `rst_n` is low, the selected index becomes 0 and the identification sequence restarts. The enable, address and power registers load the strap-selected defaults; for example, strap 0 gives 0x4F/0x10/0x00, strap 12 gives 0x0F/0x10/0x00 and strap 31 gives 0x00/0x10/0x02. `cfg_pulse` is low.
- R2: With `port_sel`=0, the first read after reset returns 0x88 and the second returns 0x00. Every later index read returns the selected index. The sequence step advances on the clock edge that ends the read and stays at index readback from then on.
- R3: A write with `port_sel`=0 stores `wdata` as the selected index and ends the identification sequence at once.
- R4: With `port_sel`=1, an access reaches the register the index selects: 0 is enable, 1 is address and 2 is power/test. For an index of 3 or more, writes change nothing and reads return 0x00.
- R5: `cfg_pulse` is high for exactly the one cycle after each accepted data write to register 0, 1 or 2. It stays low after index writes and dropped writes.
- R6: Enable register bits: bit 0 enables the parallel port, bit 1 serial port 0, bit 2 serial port 1, bit 3 the floppy controller and bit 6 the disk controller.
- R7: The floppy base is 0x370 when enable bit 5 is 1 and 0x3F0 when it is 0, with IRQ 6. The disk base is 0x170 when enable bit 7 is 1 and 0x1F0 when it is 0, with IRQ 14. The disk alternate-status base equals the disk base plus 0x206.
- R8: Address bits [1:0] pick the parallel base: 0 gives 0x378, 1 gives 0x3BC, 2 gives 0x278, and 3 means no port, so the port is disabled. Code 0 gives IRQ 7 when power register bit 3 is 1 and IRQ 5 when it is 0. Code 1 gives IRQ 7 and code 2 gives IRQ 5.
- R9: Serial port n takes its code from address bits [2n+3:2n+2]. Code 0 gives base 0x3F8 and code 1 gives 0x2F8. Address bits [7:6] then select among four bases: code 2 gives 0x3E8, 0x338, 0x2E8 or 0x220, and code 3 gives 0x2E8, 0x238, 0x2E0 or 0x228. The IRQ is 3 for odd codes and 4 for even codes.
- R10: A disabled function drives base 0 and IRQ 0. For the disk controller, this covers the alternate-status base as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; strap is sampled while it is low |
| strap | input | 5 | Default-set selector |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| port_sel | input | 1 | Bus address bit 0: 0 selects the index port, 1 the data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid while rd_en is high |
| cfg_pulse | output | 1 | One-cycle strobe after an accepted register write |
| par_en | output | 1 | Parallel port enabled |
| par_base | output | 16 | Parallel I/O base |
| par_irq | output | 4 | Parallel IRQ |
| ser_en | output | 2 | Serial port enables, bit n for port n |
| ser_base | output | 32 | Serial bases, port n in bits [16n+15:16n] |
| ser_irq | output | 8 | Serial IRQs, port n in bits [4n+3:4n] |
| fdc_en | output | 1 | Floppy controller enabled |
| fdc_base | output | 16 | Floppy I/O base |
| fdc_irq | output | 4 | Floppy IRQ |
| ide_en | output | 1 | Disk controller enabled |
| ide_base | output | 16 | Disk command-block base |
| ide_alt_base | output | 16 | Disk alternate-status base |
| ide_irq | output | 4 | Disk IRQ |

## Verification
The bench checks that the identification sequence saturates. If the step counter wrapped, a fourth index read would return 0x88 again instead of the index. It writes the index port in the middle of the sequence: a design that did not end the sequence there would return 0x00 where the new index is expected. It selects out-of-range indexes to catch designs that alias a dropped write onto register 0 or 1, or that pulse the strobe for it. Random register contents and several straps exercise parallel code 3, the power-register IRQ choice, and both serial lookups selected by address bits [7:6].

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int REG_W   = 8;
  localparam int STRAP_W = 5;
  localparam int NUM_REG = 3;
  localparam int NUM_SER = 2;

  typedef enum logic [1:0] {
    ID_FIRST  = 2'd0,
    ID_SECOND = 2'd1,
    ID_DONE   = 2'd2
  } id_step_e;

  localparam logic [REG_W-1:0] ID_BYTE_A = 8'h88;
  localparam logic [REG_W-1:0] ID_BYTE_B = 8'h00;

  function automatic logic [REG_W-1:0] dflt_enable(input logic [STRAP_W-1:0] s);
    logic [REG_W-1:0] v;
    if (s <= 5'd5)       v = 8'h4F;
    else if (s <= 5'd11) v = 8'h4B;
    else if (s <= 5'd15) v = 8'h0F;
    else if (s <= 5'd19) v = 8'h49;
    else if (s <= 5'd23) v = 8'h07;
    else if (s <= 5'd29) v = 8'h47;
    else if (s == 5'd30) v = 8'h08;
    else                 v = 8'h00;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] dflt_addr(input logic [STRAP_W-1:0] s);
    logic [REG_W-1:0] v;
    case (s)
      5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:  v = 8'h11;
      5'd3, 5'd14, 5'd22, 5'd27:               v = 8'h39;
      5'd4, 5'd15, 5'd23, 5'd28:               v = 8'h24;
      5'd5, 5'd29:                             v = 8'h38;
      5'd6, 5'd16, 5'd19:                      v = 8'h00;
      5'd7, 5'd8, 5'd17, 5'd18:                v = 8'h01;
      5'd9:                                    v = 8'h09;
      5'd10, 5'd11:                            v = 8'h08;
      default:                                 v = 8'h10;
    endcase
    return v;
  endfunction

  function automatic logic [REG_W-1:0] dflt_power(input logic [STRAP_W-1:0] s);
    return (s == 5'd31) ? 8'h02 : 8'h00;
  endfunction

  // Serial bases for codes 2 (odd=0) and 3 (odd=1), picked by address bits [7:6].
  function automatic logic [15:0] ser_alt_base(input logic odd, input logic [1:0] sel);
    logic [15:0] v;
    case ({odd, sel})
      3'b000: v = 16'h03E8;
      3'b001: v = 16'h0338;
      3'b010: v = 16'h02E8;
      3'b011: v = 16'h0220;
      3'b100: v = 16'h02E8;
      3'b101: v = 16'h0238;
      3'b110: v = 16'h02E0;
      default: v = 16'h0228;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               port_sel,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic [REG_W-1:0]   sel_idx,
  output logic [REG_W-1:0]   en_reg,
  output logic [REG_W-1:0]   addr_reg,
  output logic [REG_W-1:0]   pwr_reg,
  output logic               cfg_pulse
);
  localparam logic [REG_W-1:0] LAST_IDX = REG_W'(NUM_REG);

  id_step_e step_q;
  logic     idx_ok;

  assign idx_ok = (sel_idx < LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q    <= ID_FIRST;
      sel_idx   <= '0;
      en_reg    <= dflt_enable(strap);
      addr_reg  <= dflt_addr(strap);
      pwr_reg   <= dflt_power(strap);
      cfg_pulse <= 1'b0;
    end else begin
      cfg_pulse <= 1'b0;
      if (wr_en) begin
        if (!port_sel) begin
          sel_idx <= wdata;
          step_q  <= ID_DONE;
        end else if (idx_ok) begin
          cfg_pulse <= 1'b1;
          case (sel_idx[1:0])
            2'd0:    en_reg   <= wdata;
            2'd1:    addr_reg <= wdata;
            default: pwr_reg  <= wdata;
          endcase
        end
      end else if (rd_en && !port_sel) begin
        case (step_q)
          ID_FIRST:  step_q <= ID_SECOND;
          ID_SECOND: step_q <= ID_DONE;
          default:   step_q <= ID_DONE;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (!port_sel) begin
        case (step_q)
          ID_FIRST:  rdata = ID_BYTE_A;
          ID_SECOND: rdata = ID_BYTE_B;
          default:   rdata = sel_idx;
        endcase
      end else if (idx_ok) begin
        case (sel_idx[1:0])
          2'd0:    rdata = en_reg;
          2'd1:    rdata = addr_reg;
          default: rdata = pwr_reg;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
#(
  parameter int IO_W  = 16,
  parameter int IRQ_W = 4
) (
  input  logic [REG_W-1:0]         en_reg,
  input  logic [REG_W-1:0]         addr_reg,
  input  logic [REG_W-1:0]         pwr_reg,
  output logic                     par_en,
  output logic [IO_W-1:0]          par_base,
  output logic [IRQ_W-1:0]         par_irq,
  output logic [NUM_SER-1:0]       ser_en,
  output logic [NUM_SER*IO_W-1:0]  ser_base,
  output logic [NUM_SER*IRQ_W-1:0] ser_irq,
  output logic                     fdc_en,
  output logic [IO_W-1:0]          fdc_base,
  output logic [IRQ_W-1:0]         fdc_irq,
  output logic                     ide_en,
  output logic [IO_W-1:0]          ide_base,
  output logic [IO_W-1:0]          ide_alt_base,
  output logic [IRQ_W-1:0]         ide_irq
);
  localparam logic [IO_W-1:0] IDE_ALT_OFS = IO_W'(16'h0206);

  // Parallel port
  logic [1:0] par_code;
  assign par_code = addr_reg[1:0];
  assign par_en   = en_reg[0] && (par_code != 2'd3);

  always_comb begin
    par_base = '0;
    par_irq  = '0;
    if (par_en) begin
      case (par_code)
        2'd0: begin
          par_base = IO_W'(16'h0378);
          par_irq  = pwr_reg[3] ? IRQ_W'(7) : IRQ_W'(5);
        end
        2'd1: begin
          par_base = IO_W'(16'h03BC);
          par_irq  = IRQ_W'(7);
        end
        default: begin
          par_base = IO_W'(16'h0278);
          par_irq  = IRQ_W'(5);
        end
      endcase
    end
  end

  // Serial ports
  for (genvar g = 0; g < NUM_SER; g++) begin : g_ser
    logic [1:0]       code;
    logic [IO_W-1:0]  base;
    assign code      = addr_reg[2*g+3 -: 2];
    assign ser_en[g] = en_reg[1+g];
    always_comb begin
      case (code)
        2'd0:    base = IO_W'(16'h03F8);
        2'd1:    base = IO_W'(16'h02F8);
        default: base = IO_W'(ser_alt_base(code[0], addr_reg[7:6]));
      endcase
    end
    assign ser_base[g*IO_W +: IO_W]   = ser_en[g] ? base : '0;
    assign ser_irq[g*IRQ_W +: IRQ_W]  = !ser_en[g] ? '0 :
                                        (code[0] ? IRQ_W'(3) : IRQ_W'(4));
  end

  // Floppy controller
  assign fdc_en   = en_reg[3];
  assign fdc_base = !fdc_en ? '0 : (en_reg[5] ? IO_W'(16'h0370) : IO_W'(16'h03F0));
  assign fdc_irq  = fdc_en ? IRQ_W'(6) : '0;

  // Disk controller
  logic [IO_W-1:0] ide_cmd;
  assign ide_en       = en_reg[6];
  assign ide_cmd      = en_reg[7] ? IO_W'(16'h0170) : IO_W'(16'h01F0);
  assign ide_base     = ide_en ? ide_cmd : '0;
  assign ide_alt_base = ide_en ? (ide_cmd + IDE_ALT_OFS) : '0;
  assign ide_irq      = ide_en ? IRQ_W'(14) : '0;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int IO_W  = 16,
  parameter int IRQ_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [STRAP_W-1:0]       strap,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic                     port_sel,
  input  logic [REG_W-1:0]         wdata,
  output logic [REG_W-1:0]         rdata,
  output logic                     cfg_pulse,
  output logic                     par_en,
  output logic [IO_W-1:0]          par_base,
  output logic [IRQ_W-1:0]         par_irq,
  output logic [NUM_SER-1:0]       ser_en,
  output logic [NUM_SER*IO_W-1:0]  ser_base,
  output logic [NUM_SER*IRQ_W-1:0] ser_irq,
  output logic                     fdc_en,
  output logic [IO_W-1:0]          fdc_base,
  output logic [IRQ_W-1:0]         fdc_irq,
  output logic                     ide_en,
  output logic [IO_W-1:0]          ide_base,
  output logic [IO_W-1:0]          ide_alt_base,
  output logic [IRQ_W-1:0]         ide_irq
);
  logic [REG_W-1:0] sel_idx;
  logic [REG_W-1:0] en_reg;
  logic [REG_W-1:0] addr_reg;
  logic [REG_W-1:0] pwr_reg;

  sio_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (strap),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .port_sel  (port_sel),
    .wdata     (wdata),
    .rdata     (rdata),
    .sel_idx   (sel_idx),
    .en_reg    (en_reg),
    .addr_reg  (addr_reg),
    .pwr_reg   (pwr_reg),
    .cfg_pulse (cfg_pulse)
  );

  sio_cfg_decode #(.IO_W(IO_W), .IRQ_W(IRQ_W)) u_dec (
    .en_reg       (en_reg),
    .addr_reg     (addr_reg),
    .pwr_reg      (pwr_reg),
    .par_en       (par_en),
    .par_base     (par_base),
    .par_irq      (par_irq),
    .ser_en       (ser_en),
    .ser_base     (ser_base),
    .ser_irq      (ser_irq),
    .fdc_en       (fdc_en),
    .fdc_base     (fdc_base),
    .fdc_irq      (fdc_irq),
    .ide_en       (ide_en),
    .ide_base     (ide_base),
    .ide_alt_base (ide_alt_base),
    .ide_irq      (ide_irq)
  );
endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk
  import sio_cfg_pkg::*;
#(
  parameter int IO_W  = 16,
  parameter int IRQ_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic                     port_sel,
  input logic [REG_W-1:0]         sel_idx,
  input logic [REG_W-1:0]         rdata,
  input logic                     cfg_pulse,
  input logic                     par_en,
  input logic [IRQ_W-1:0]         par_irq,
  input logic [NUM_SER-1:0]       ser_en,
  input logic [NUM_SER*IRQ_W-1:0] ser_irq,
  input logic                     fdc_en,
  input logic [IO_W-1:0]          fdc_base,
  input logic [IRQ_W-1:0]         fdc_irq,
  input logic                     ide_en,
  input logic [IO_W-1:0]          ide_base,
  input logic [IO_W-1:0]          ide_alt_base
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  assert_pulse_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (cfg_pulse == $past(wr_en && port_sel && (sel_idx < REG_W'(NUM_REG)))));

  assert_bad_idx_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && port_sel && (sel_idx >= REG_W'(NUM_REG))) |-> (rdata == '0));

  assert_idx_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wr_en && !port_sel) && rd_en && !port_sel && !wr_en) |-> (rdata == sel_idx));

  assert_fdc_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fdc_en |-> (fdc_base == '0 && fdc_irq == '0));

  assert_ide_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ide_en |-> (ide_alt_base == ide_base + IO_W'(16'h0206)));

  assert_par_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par_en |-> (par_irq == IRQ_W'(5) || par_irq == IRQ_W'(7)));

  assert_ser0_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en[0] |-> (ser_irq[IRQ_W-1:0] == IRQ_W'(3) || ser_irq[IRQ_W-1:0] == IRQ_W'(4)));
endmodule

bind sio_cfg_port sio_cfg_chk #(.IO_W(IO_W), .IRQ_W(IRQ_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .port_sel     (port_sel),
  .sel_idx      (sel_idx),
  .rdata        (rdata),
  .cfg_pulse    (cfg_pulse),
  .par_en       (par_en),
  .par_irq      (par_irq),
  .ser_en       (ser_en),
  .ser_irq      (ser_irq),
  .fdc_en       (fdc_en),
  .fdc_base     (fdc_base),
  .fdc_irq      (fdc_irq),
  .ide_en       (ide_en),
  .ide_base     (ide_base),
  .ide_alt_base (ide_alt_base)
);

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/1ps
module sim_sio_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap = 5'd1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        port_sel = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        cfg_pulse;
  logic        par_en;
  logic [15:0] par_base;
  logic [3:0]  par_irq;
  logic [1:0]  ser_en;
  logic [31:0] ser_base;
  logic [7:0]  ser_irq;
  logic        fdc_en;
  logic [15:0] fdc_base;
  logic [3:0]  fdc_irq;
  logic        ide_en;
  logic [15:0] ide_base;
  logic [15:0] ide_alt_base;
  logic [3:0]  ide_irq;

  always #4 clk = ~clk;

  sio_cfg_port u0 (.*);

  int total = 0;
  int bad   = 0;

  // bench model
  logic [7:0] m_en, m_addr, m_pwr, m_idx;
  int         m_step;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] t_en(input int s);
    if (s <= 5) return 8'h4F;
    if (s <= 11) return 8'h4B;
    if (s <= 15) return 8'h0F;
    if (s <= 19) return 8'h49;
    if (s <= 23) return 8'h07;
    if (s <= 29) return 8'h47;
    if (s == 30) return 8'h08;
    return 8'h00;
  endfunction

  function automatic logic [7:0] t_addr(input int s);
    case (s)
      1, 2, 13, 21, 25, 26: return 8'h11;
      3, 14, 22, 27:        return 8'h39;
      4, 15, 23, 28:        return 8'h24;
      5, 29:                return 8'h38;
      6, 16, 19:            return 8'h00;
      7, 8, 17, 18:         return 8'h01;
      9:                    return 8'h09;
      10, 11:               return 8'h08;
      default:              return 8'h10;
    endcase
  endfunction

  function automatic logic [15:0] exp_ser_base(input int n);
    logic [1:0] c = m_addr[2*n+2 +: 2];
    logic [1:0] s = m_addr[7:6];
    if (!m_en[1+n]) return 16'h0;
    if (c == 0) return 16'h03F8;
    if (c == 1) return 16'h02F8;
    if (c == 2) return (s == 0) ? 16'h03E8 : (s == 1) ? 16'h0338 : (s == 2) ? 16'h02E8 : 16'h0220;
    return (s == 0) ? 16'h02E8 : (s == 1) ? 16'h0238 : (s == 2) ? 16'h02E0 : 16'h0228;
  endfunction

  task automatic check_map();
    logic [1:0]  pc = m_addr[1:0];
    logic        pen = m_en[0] && pc != 2'd3;
    logic [15:0] pb;
    logic [3:0]  pi;
    logic [15:0] ib;
    pb = !pen ? 16'h0 : (pc == 0) ? 16'h0378 : (pc == 1) ? 16'h03BC : 16'h0278;
    pi = !pen ? 4'd0 : (pc == 0) ? (m_pwr[3] ? 4'd7 : 4'd5) : (pc == 1) ? 4'd7 : 4'd5;
    check("R6/R8 par_en", par_en, pen);
    check("R8/R10 par_base", par_base, pb);
    check("R8/R10 par_irq", par_irq, pi);
    check("R6 ser_en", ser_en, m_en[2:1]);
    for (int n = 0; n < 2; n++) begin
      check("R9/R10 ser_base", ser_base[16*n +: 16], exp_ser_base(n));
      check("R9/R10 ser_irq", ser_irq[4*n +: 4],
            !m_en[1+n] ? 4'd0 : (m_addr[2*n+2] ? 4'd3 : 4'd4));
    end
    check("R6 fdc_en", fdc_en, m_en[3]);
    check("R7/R10 fdc_base", fdc_base, !m_en[3] ? 16'h0 : (m_en[5] ? 16'h0370 : 16'h03F0));
    check("R7/R10 fdc_irq", fdc_irq, m_en[3] ? 4'd6 : 4'd0);
    ib = m_en[7] ? 16'h0170 : 16'h01F0;
    check("R6 ide_en", ide_en, m_en[6]);
    check("R7/R10 ide_base", ide_base, m_en[6] ? ib : 16'h0);
    check("R7/R10 ide_alt_base", ide_alt_base, m_en[6] ? ib + 16'h0206 : 16'h0);
    check("R7/R10 ide_irq", ide_irq, m_en[6] ? 4'd14 : 4'd0);
  endtask

  task automatic do_reset(input int s);
    @(negedge clk);
    rst_n = 1'b0; strap = 5'(s);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_en = t_en(s); m_addr = t_addr(s); m_pwr = (s == 31) ? 8'h02 : 8'h00;
    m_idx = 8'h00; m_step = 0;
    check("R1 pulse low", cfg_pulse, 1'b0);
    check_map();
  endtask

  task automatic do_write(input logic sel, input logic [7:0] d);
    logic acc;
    @(negedge clk);
    wr_en = 1'b1; port_sel = sel; wdata = d;
    acc = sel && (m_idx < 3);
    @(negedge clk);
    wr_en = 1'b0;
    if (!sel) begin m_idx = d; m_step = 2; end
    else if (acc) begin
      if (m_idx == 0) m_en = d; else if (m_idx == 1) m_addr = d; else m_pwr = d;
    end
    check("R5 cfg_pulse", cfg_pulse, acc);
    check_map();
  endtask

  task automatic do_read(input logic sel, input string req);
    logic [7:0] e;
    @(negedge clk);
    rd_en = 1'b1; port_sel = sel;
    if (!sel) begin
      e = (m_step == 0) ? 8'h88 : (m_step == 1) ? 8'h00 : m_idx;
      if (m_step < 2) m_step++;
    end else begin
      e = (m_idx == 0) ? m_en : (m_idx == 1) ? m_addr : (m_idx == 2) ? m_pwr : 8'h00;
    end
    #1;
    check(req, rdata, e);
    @(negedge clk);
    rd_en = 1'b0;
    check("R5 no pulse on read", cfg_pulse, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h51C0);
    // R1 strap defaults, R2 ID sequence with saturation
    do_reset(0);
    do_read(1'b1, "R1 enable default strap0");
    do_reset(12);
    do_read(1'b1, "R1 enable default strap12");
    do_reset(31);
    do_write(1'b0, 8'd2);
    do_read(1'b1, "R1 power default strap31");
    do_reset(1);
    do_read(1'b0, "R2 id byte0");
    do_read(1'b0, "R2 id byte1");
    do_read(1'b0, "R2 index readback");
    do_read(1'b0, "R2 saturated");
    // R3 index write mid-sequence
    do_reset(1);
    do_read(1'b0, "R2 id byte0");
    do_write(1'b0, 8'd1);
    do_read(1'b0, "R3 index after write");
    do_read(1'b1, "R4 addr read");
    // R4 out-of-range index
    do_write(1'b0, 8'd3);
    do_write(1'b1, 8'hFF);
    do_read(1'b1, "R4 bad index reads zero");
    do_write(1'b0, 8'hC0);
    do_write(1'b1, 8'h55);
    for (int i = 0; i < 3; i++) begin
      do_write(1'b0, 8'(i));
      do_read(1'b1, "R4 untouched by dropped write");
    end
    // R8 parallel code 0 with power bit 3
    do_write(1'b0, 8'd0); do_write(1'b1, 8'h01);
    do_write(1'b0, 8'd1); do_write(1'b1, 8'h00);
    do_write(1'b0, 8'd2); do_write(1'b1, 8'h08);
    do_write(1'b1, 8'h00);
    do_write(1'b0, 8'd1); do_write(1'b1, 8'h03);
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int op = $urandom % 10;
      if (op == 0 && ($urandom % 20) == 0) do_reset($urandom % 32);
      else if (op <= 2) do_write(1'b0, ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 4));
      else if (op <= 6) do_write(1'b1, 8'($urandom));
      else if (op == 7) do_read(1'b0, "R2/R3 index read");
      else do_read(1'b1, "R4 data read");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule